// File: doc/BRIEF.md
# Prescreened Byte-Serial Unsigned Multiplier

This block multiplies two unsigned 32-bit operands and returns the low 32 bits of the product together with an overflow flag. Before it does any arithmetic, it compares the significant-bit lengths of the two operands. The significant-bit length of a value is the index of its highest set bit plus one, and it is 0 for zero. From this comparison the block decides whether the product can fit in 32 bits. An operation that is certain to overflow, or that has a zero operand, finishes right after this screening step.

An operation that passes the screen has one operand of 16 or fewer significant bits. That operand becomes the multiplier, and the block walks it one 8-bit digit per cycle. For each digit it forms the full multiplicand-by-digit partial product in one step, shifts it into place and adds it to a 48-bit accumulator. So a surviving operation costs one or two passes instead of a 32-step bit loop.

A caller offers operands with a valid/ready handshake. It then waits for a one-cycle done pulse that carries the result and the overflow flag.

Top module: `mulpre_top`

## Requirements
- R1: After reset, start_ready is 1, done is 0, result is 0 and overflow is 0.
- R2: Operands are captured only on a clock edge where start_valid and start_ready are both 1. start_ready stays 0 from that edge until done pulses, and changes on op_a/op_b during that time do not alter the result.
- R3: If either operand is zero, done is 1 in the cycle after the acceptance edge, with result 0 and overflow 0.
- R4: If the two significant-bit lengths add up to more than 33, done is 1 in the cycle after the acceptance edge, with overflow 1 and result 0.
- R5: If the lengths add up to 32 or less (and no operand is zero), result equals the exact product and overflow is 0.
- R6: If the lengths add up to exactly 33, result is the low 32 bits of the product and overflow equals bit 32 of the product.
- R7: The operand with fewer significant bits is the multiplier (op_b on a tie), so swapping the operands leaves the result and the latency unchanged. Done is 1 exactly 1+N cycles after the acceptance edge, where N is the multiplier's length divided by 8, rounded up.
- R8: A multiplier of 255 or less takes exactly one pass. A multiplier from 256 to 65535 takes exactly two passes.
- R9: done is high for a single cycle. result and overflow hold their values until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Operands on op_a/op_b are offered |
| start_ready | output | 1 | Block is idle and can take operands |
| op_a | input | 32 | First unsigned operand |
| op_b | input | 32 | Second unsigned operand |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Low 32 bits of the product (0 when rejected) |
| overflow | output | 1 | Product does not fit in 32 bits |

## Verification
The assertions assume that start_valid is never unknown once reset has been released. They also assume the operands are sampled only on the acceptance edge, so the block never depends on op_a/op_b holding steady while it is busy. The stimulus drives every input on the falling edge, so all inputs are settled at each rising edge. After every acceptance it deliberately scrambles the operand ports, so that any reliance on unregistered operands shows up as a wrong result.

// File: rtl/mulpre_pkg.sv
package mulpre_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCREEN,
    ST_PASS
  } mp_state_t;

  // Significant-bit length: index of the top set bit plus one (0 for zero).
  function automatic logic [7:0] sig_len(input logic [63:0] v);
    logic [7:0] n;
    n = '0;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) n = 8'(i + 1);
    end
    return n;
  endfunction

  // Digit passes needed for a multiplier of the given length.
  function automatic int digit_passes(input int len, input int dig);
    return (len + dig - 1) / dig;
  endfunction

endpackage

// File: rtl/mulpre_screen.sv
module mulpre_screen
  import mulpre_pkg::*;
#(
  parameter int W    = 32,
  parameter int DIG  = 8,
  parameter int LW   = $clog2(W + 1),
  parameter int PW   = 2
) (
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  output logic          is_zero,
  output logic          is_reject,
  output logic          is_edge,
  output logic [W-1:0]  mcand,
  output logic [W-1:0]  mplier,
  output logic [PW-1:0] npass
);

  logic [LW-1:0] len_a, len_b, len_m;
  logic [LW:0]   len_sum;
  logic          a_is_short;

  assign len_a      = LW'(sig_len(64'(opa)));
  assign len_b      = LW'(sig_len(64'(opb)));
  assign len_sum    = {1'b0, len_a} + {1'b0, len_b};
  assign a_is_short = len_a < len_b;

  assign is_zero    = (opa == '0) || (opb == '0);
  assign is_reject  = !is_zero && (int'(len_sum) > W + 1);
  assign is_edge    = !is_zero && (int'(len_sum) == W + 1);

  assign mcand  = a_is_short ? opb : opa;
  assign mplier = a_is_short ? opa : opb;
  assign len_m  = a_is_short ? len_a : len_b;
  assign npass  = PW'(digit_passes(int'(len_m), DIG));

  always_comb begin
    if (!is_zero && !is_reject) begin
      AST_SHORT_MPLIER: assert (int'(len_m) <= W / 2); // R7
      AST_PASS_COUNT: assert (npass != '0); // R8
    end
  end

endmodule

// File: rtl/mulpre_digit.sv
module mulpre_digit #(
  parameter int W     = 32,
  parameter int DIG   = 8,
  parameter int ACC_W = 48,
  parameter int PW    = 2
) (
  input  logic [W-1:0]     mcand,
  input  logic [W-1:0]     mplier,
  input  logic [PW-1:0]    idx,
  output logic [ACC_W-1:0] pp_aligned
);

  logic [DIG-1:0] digit;

  // Whole-digit product, then alignment by the digit position.
  always_comb begin
    int sh;
    sh         = int'(idx) * DIG;
    digit      = DIG'(mplier >> sh);
    pp_aligned = (ACC_W'(mcand) * ACC_W'(digit)) << sh;
  end

endmodule

// File: rtl/mulpre_top.sv
module mulpre_top
  import mulpre_pkg::*;
#(
  parameter int W   = 32,
  parameter int DIG = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_valid,
  output logic         start_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         done,
  output logic [W-1:0] result,
  output logic         overflow
);

  localparam int MAXP  = (W / 2 + DIG - 1) / DIG;
  localparam int PW    = $clog2(MAXP + 1);
  localparam int ACC_W = W + MAXP * DIG;
  localparam int LW    = $clog2(W + 1);

  mp_state_t         state;
  logic [W-1:0]      opa_q, opb_q, mcand_q, mplier_q;
  logic [PW-1:0]     npass_q, idx_q;
  logic [ACC_W-1:0]  acc_q;
  logic [W-1:0]      res_q;
  logic              ovf_q, done_q;

  // Named events for the assertions.
  logic              accept, scr_zero, scr_reject, scr_edge, pass_last;
  logic [W-1:0]      scr_mcand, scr_mplier;
  logic [PW-1:0]     scr_npass;
  logic [ACC_W-1:0]  pp, acc_nxt;

  assign start_ready = (state == ST_IDLE);
  assign accept      = start_valid && start_ready;

  mulpre_screen #(.W(W), .DIG(DIG), .LW(LW), .PW(PW)) u_screen (
    .opa       (opa_q),
    .opb       (opb_q),
    .is_zero   (scr_zero),
    .is_reject (scr_reject),
    .is_edge   (scr_edge),
    .mcand     (scr_mcand),
    .mplier    (scr_mplier),
    .npass     (scr_npass)
  );

  mulpre_digit #(.W(W), .DIG(DIG), .ACC_W(ACC_W), .PW(PW)) u_digit (
    .mcand      (mcand_q),
    .mplier     (mplier_q),
    .idx        (idx_q),
    .pp_aligned (pp)
  );

  assign acc_nxt   = acc_q + pp;
  assign pass_last = (state == ST_PASS) && (idx_q == npass_q - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      opa_q    <= '0;
      opb_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      npass_q  <= '0;
      idx_q    <= '0;
      acc_q    <= '0;
      res_q    <= '0;
      ovf_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            opa_q <= op_a;
            opb_q <= op_b;
            state <= ST_SCREEN;
          end
        end
        ST_SCREEN: begin
          if (scr_zero || scr_reject) begin
            res_q  <= '0;
            ovf_q  <= scr_reject;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            mcand_q  <= scr_mcand;
            mplier_q <= scr_mplier;
            npass_q  <= scr_npass;
            idx_q    <= '0;
            acc_q    <= '0;
            state    <= ST_PASS;
          end
        end
        ST_PASS: begin
          acc_q <= acc_nxt;
          if (pass_last) begin
            res_q  <= acc_nxt[W-1:0];
            ovf_q  <= |acc_nxt[ACC_W-1:W];
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            idx_q <= idx_q + PW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done     = done_q;
  assign result   = res_q;
  assign overflow = ovf_q;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) accept |=> !start_ready); // R2
  AST_ZERO_EARLY: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_SCREEN && scr_zero) |=> (done && result == '0 && !overflow)); // R3
  AST_REJECT_EARLY: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_SCREEN && scr_reject) |=> (done && overflow)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_SCREEN && !scr_zero && !scr_reject && !scr_edge) |-> (scr_mplier < (W'(1) << (W / 2)))); // R5
  AST_PASS_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_PASS) |-> (int'(idx_q) < MAXP)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(result) && $stable(overflow)); // R9

endmodule

// File: tb/mulpre_top_tb.sv
module mulpre_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [31:0] op_a = '0, op_b = '0;
  logic        done;
  logic [31:0] result;
  logic        overflow;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  mulpre_top u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .op_a(op_a), .op_b(op_b), .done(done), .result(result), .overflow(overflow)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int blen(input logic [31:0] v);
    int n = 0;
    for (int i = 31; i >= 0; i--) if (v[i] && n == 0) n = i + 1;
    return n;
  endfunction

  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] full;
    logic [31:0] exp_res;
    logic        exp_ovf;
    int la, lb, lm, exp_lat, lat, guard;
    la = blen(a);
    lb = blen(b);
    full = {32'd0, a} * {32'd0, b};
    if (a == 0 || b == 0) begin
      exp_res = 0; exp_ovf = 0; exp_lat = 1;
    end else if (la + lb > 33) begin
      exp_res = 0; exp_ovf = 1; exp_lat = 1;
    end else begin
      exp_res = full[31:0];
      exp_ovf = (full[63:32] != 0);
      lm = (la < lb) ? la : lb;
      exp_lat = 1 + (lm + 7) / 8;
    end
    guard = 0;
    while (!start_ready && guard < 50) begin @(negedge clk); guard++; end
    op_a = a; op_b = b; start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    op_a = ~a; op_b = a ^ 32'h5A5A_A5A5;
    chk("R2", "ready low after accept", start_ready, 0);
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
      if (!done) chk("R2", "ready low while busy", start_ready, 0);
    end
    chk(req, "latency", lat, exp_lat);
    chk(req, "result", result, exp_res);
    chk(req, "overflow", overflow, exp_ovf);
    @(negedge clk);
    chk("R9", "done single cycle", done, 0);
    chk("R9", "result held", result, exp_res);
    chk("R9", "overflow held", overflow, exp_ovf);
  endtask

  task automatic t_reset;
    chk("R1", "ready", start_ready, 1);
    chk("R1", "done", done, 0);
    chk("R1", "result", result, 0);
    chk("R1", "overflow", overflow, 0);
  endtask

  task automatic t_zero;
    run_op("R3", 32'd0, 32'hFFFF_FFFF);
    run_op("R3", 32'h1234_5678, 32'd0);
  endtask

  task automatic t_reject;
    run_op("R4", 32'h8000_0000, 32'd2);
    run_op("R4", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R4", 32'h0002_0000, 32'h0001_0000);
  endtask

  task automatic t_fit;
    run_op("R5", 32'd123, 32'd45);
    run_op("R5", 32'h0000_FFFF, 32'h0000_FFFF);
    run_op("R5", 32'h00AB_CDEF, 32'h0000_00FE);
  endtask

  task automatic t_edge33;
    run_op("R6", 32'h0000_FFFF, 32'h0001_FFFF);
    run_op("R6", 32'h0001_0000, 32'h0000_8000);
    run_op("R6", 32'hFFFF_FFFF, 32'd1);
  endtask

  task automatic t_swap;
    run_op("R7", 32'h0001_2345, 32'd7);
    run_op("R7", 32'd7, 32'h0001_2345);
    run_op("R7", 32'h0000_8001, 32'h0000_C003);
  endtask

  task automatic t_passes;
    run_op("R8", 32'h00FF_FFFF, 32'd255);
    run_op("R8", 32'h0000_FFFF, 32'd256);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_reject();
    t_fit();
    t_edge33();
    t_swap();
    t_passes();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule